// File: doc/BRIEF.md
# Idle-Cycle Memory CRC Checker

This block checks the integrity of a region of program memory in the background. It computes a CRC-32 over the region and compares the result with a golden value. It reads the memory only in cycles where the host program-fetch bus reports idle, so host instruction fetches are never delayed. Each read returns one 32-bit word. The CRC datapath absorbs that word one byte per cycle over four cycles, and a one-word buffer lets the next read be issued while the current word is still being absorbed.

Two requesters share one register interface. Either one can program the start word address, the region size in 1 KB blocks and the golden value, and then start the scan. When the last byte has been absorbed, the block stores the final CRC and sets a pass/fail bit. It also sets a done flag, which drives the interrupt line and stays set until a requester writes 1 to clear it. If the size is zero or the region runs past the end of memory, the block sets an error bit and completes at once without reading memory.

Top module: `memcrc_scan`

## Requirements
- R1: After reset, the status register reads 0, the result register reads 0, `irq` is low and `mem_re` is low.
- R2: `mem_re` is high only in a cycle where `bus_idle` is high.
- R3: A scan reads word addresses start, start+1, … in order. It makes exactly 256 × size reads, where a size of n means n blocks of 1 KB.
- R4: The CRC is computed as follows. The register is preset to 0xFFFFFFFF and the polynomial is 0x04C11DB7. Each word is processed byte 0 (bits 7:0) first and byte 3 last, with the most significant bit first inside each byte. No final inversion is applied. The final value can be read at register index 4.
- R5: At most one read is outstanding at a time, and two reads are always at least 4 cycles apart.
- R6: On completion, busy clears and done and `irq` go high. Pass is 1 exactly when the CRC equals the golden value.
- R7: Writing register index 3 with bit 1 set clears done and `irq`.
- R8: While busy, writes to the configuration registers and start requests have no effect.
- R9: A start request is an error case when the size is 0 or when start + 256 × size exceeds the memory size in words. In that case, within 2 cycles the status shows error=1, done=1, pass=0 and busy=0, and no memory read is made.
- R10: When both requesters write in the same cycle, requester A's write takes effect and requester B's write is dropped.
- R11: Done is raised no sooner than 4 × (number of words) cycles after the start request.
- R12: The register indices are: 0 start word address, 1 size in blocks, 2 golden value, 3 control/status, 4 result. At index 3, a write uses bit0 to start and bit1 to clear done. A read of index 3 returns busy at bit0, done at bit1, pass at bit2 and error at bit3. Any other index reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_we | input | 1 | Requester A write strobe |
| a_sel | input | 3 | Requester A register index |
| a_wdata | input | 32 | Requester A write data |
| b_we | input | 1 | Requester B write strobe |
| b_sel | input | 3 | Requester B register index |
| b_wdata | input | 32 | Requester B write data |
| rd_sel | input | 3 | Read register index |
| rd_data | output | 32 | Read data (combinational) |
| irq | output | 1 | Done interrupt flag |
| bus_idle | input | 1 | Host program bus idle in this cycle |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 10 | Memory word address |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_re` |

## Verification
Two events can land in the same cycle: a host fetch that holds the bus and a CRC read that is ready to issue. The bench provokes this with an always-idle pattern, a pseudo-random pattern and a sparse one-in-three idle pattern. It flags any cycle where `mem_re` is high while `bus_idle` is low, and it checks that the address sequence and the final CRC still match the arithmetic reference. The second same-cycle case is both requesters writing the same register, or both starting a scan, on one edge. This is judged by reading the register back and by confirming that exactly one scan's worth of reads occurs.

// File: rtl/memcrc_pkg.sv
package memcrc_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam int          BLK_WORDS = 256;

  localparam logic [2:0] SEL_BASE   = 3'd0;
  localparam logic [2:0] SEL_SIZE   = 3'd1;
  localparam logic [2:0] SEL_GOLD   = 3'd2;
  localparam logic [2:0] SEL_CTRL   = 3'd3;
  localparam logic [2:0] SEL_RESULT = 3'd4;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {b, 24'h0};
    for (int i = 0; i < 8; i++) begin
      r = r[31] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/memcrc_regs.sv
module memcrc_regs
  import memcrc_pkg::*;
#(
  parameter int MEM_WORDS = 1024,
  parameter int AW        = 10,
  parameter int WW        = 11,
  parameter int SZW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [2:0]    a_sel,
  input  logic [31:0]   a_wdata,
  input  logic          b_we,
  input  logic [2:0]    b_sel,
  input  logic [31:0]   b_wdata,
  input  logic [2:0]    rd_sel,
  output logic [31:0]   rd_data,
  input  logic          job_end,
  input  logic [31:0]   crc_in,
  output logic          launch,
  output logic [AW-1:0] base,
  output logic [WW-1:0] nwords,
  output logic          busy
);
  logic [AW-1:0]  base_q, base_d;
  logic [SZW-1:0] size_q, size_d;
  logic [31:0]    gold_q, gold_d, res_q, res_d;
  logic           busy_q, busy_d, done_q, done_d, pass_q, pass_d, err_q, err_d;
  logic           w_en, go, cfg_bad;
  logic [2:0]     w_sel;
  logic [31:0]    w_dat, span, end_w;

  always_comb begin
    w_en    = a_we | b_we;
    w_sel   = a_we ? a_sel : b_sel;
    w_dat   = a_we ? a_wdata : b_wdata;
    span    = 32'(size_q) * 32'(BLK_WORDS);
    end_w   = 32'(base_q) + span;
    cfg_bad = (size_q == '0) || (end_w > 32'(MEM_WORDS));
    go      = w_en && (w_sel == SEL_CTRL) && w_dat[0] && !busy_q;
    launch  = go && !cfg_bad;

    base_d = base_q; size_d = size_q; gold_d = gold_q; res_d = res_q;
    busy_d = busy_q; done_d = done_q; pass_d = pass_q; err_d = err_q;

    if (w_en && !busy_q) begin
      case (w_sel)
        SEL_BASE: base_d = w_dat[AW-1:0];
        SEL_SIZE: size_d = w_dat[SZW-1:0];
        SEL_GOLD: gold_d = w_dat;
        default:  ;
      endcase
    end
    if (w_en && (w_sel == SEL_CTRL) && w_dat[1]) done_d = 1'b0;
    if (go) begin
      if (cfg_bad) begin
        done_d = 1'b1; err_d = 1'b1; pass_d = 1'b0;
      end else begin
        busy_d = 1'b1; done_d = 1'b0; err_d = 1'b0; pass_d = 1'b0;
      end
    end
    if (job_end) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      pass_d = (crc_in == gold_q);
      res_d  = crc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0; size_q <= '0; gold_q <= '0; res_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; pass_q <= 1'b0; err_q <= 1'b0;
    end else begin
      base_q <= base_d; size_q <= size_d; gold_q <= gold_d; res_q <= res_d;
      busy_q <= busy_d; done_q <= done_d; pass_q <= pass_d; err_q <= err_d;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_BASE:   rd_data = 32'(base_q);
      SEL_SIZE:   rd_data = 32'(size_q);
      SEL_GOLD:   rd_data = gold_q;
      SEL_CTRL:   rd_data = {28'h0, err_q, pass_q, done_q, busy_q};
      SEL_RESULT: rd_data = res_q;
      default:    rd_data = 32'h0;
    endcase
  end

  assign base   = base_q;
  assign nwords = span[WW-1:0];
  assign busy   = busy_q;

  // R8
  gold_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(gold_q));
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !busy_q);
  // R9
  err_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!busy_q && !pass_q && done_q) || $fell(done_q) || !done_q);
endmodule

// File: rtl/memcrc_fetch.sv
module memcrc_fetch #(
  parameter int AW = 10,
  parameter int WW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [AW-1:0] base,
  input  logic [WW-1:0] count,
  input  logic          bus_idle,
  input  logic          slot_ok,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic          rvalid,
  output logic          drained
);
  logic [AW-1:0] addr_q, addr_d;
  logic [WW-1:0] left_q, left_d;
  logic          pend_q, pend_d;

  always_comb begin
    mem_re  = bus_idle && (left_q != '0) && !pend_q && slot_ok;
    addr_d  = addr_q;
    left_d  = left_q;
    pend_d  = mem_re;
    if (launch) begin
      addr_d = base;
      left_d = count;
    end else if (mem_re) begin
      addr_d = addr_q + 1'b1;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; left_q <= '0; pend_q <= 1'b0;
    end else begin
      addr_q <= addr_d; left_q <= left_d; pend_q <= pend_d;
    end
  end

  assign mem_addr = addr_q;
  assign rvalid   = pend_q;
  assign drained  = (left_q == '0) && !pend_q;

  // checker state: spacing and address progression
  logic [2:0]    gap_q;
  logic          seen_q;
  logic [AW-1:0] prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0; seen_q <= 1'b0; prev_q <= '0;
    end else begin
      if (mem_re) gap_q <= '0;
      else if (gap_q != 3'd7) gap_q <= gap_q + 3'd1;
      if (launch) seen_q <= 1'b0;
      else if (mem_re) seen_q <= 1'b1;
      if (mem_re) prev_q <= mem_addr;
    end
  end

  // R2
  idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> bus_idle);
  // R5
  read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && seen_q) |-> (gap_q >= 3'd3));
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && seen_q) |-> (mem_addr == prev_q + 1'b1));
endmodule

// File: rtl/memcrc_engine.sv
module memcrc_engine
  import memcrc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        load,
  input  logic [31:0] word,
  output logic [31:0] crc,
  output logic        slot_ok,
  output logic        idle
);
  logic [31:0] wbuf_q, wbuf_d, crc_q, crc_d;
  logic [1:0]  bcnt_q, bcnt_d;
  logic        wv_q, wv_d;
  logic [7:0]  cur;

  always_comb begin
    cur    = wbuf_q[{bcnt_q, 3'b000} +: 8];
    wbuf_d = wbuf_q;
    crc_d  = crc_q;
    bcnt_d = bcnt_q;
    wv_d   = wv_q;
    if (init) begin
      crc_d = CRC_SEED;
      wv_d  = 1'b0;
      bcnt_d = 2'd0;
    end else begin
      if (wv_q) begin
        crc_d  = crc_byte(crc_q, cur);
        bcnt_d = bcnt_q + 2'd1;
        if (bcnt_q == 2'd3) wv_d = 1'b0;
      end
      if (load) begin
        wbuf_d = word;
        bcnt_d = 2'd0;
        wv_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbuf_q <= '0; crc_q <= CRC_SEED; bcnt_q <= '0; wv_q <= 1'b0;
    end else begin
      wbuf_q <= wbuf_d; crc_q <= crc_d; bcnt_q <= bcnt_d; wv_q <= wv_d;
    end
  end

  assign crc     = crc_q;
  assign slot_ok = !wv_q || bcnt_q[1];
  assign idle    = !wv_q;

  // R5
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!wv_q || bcnt_q == 2'd3));
endmodule

// File: rtl/memcrc_scan.sv
module memcrc_scan #(
  parameter int MEM_WORDS = 1024,
  localparam int AW  = $clog2(MEM_WORDS),
  localparam int WW  = $clog2(MEM_WORDS + 1),
  localparam int SZW = $clog2(MEM_WORDS / 256 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [2:0]    a_sel,
  input  logic [31:0]   a_wdata,
  input  logic          b_we,
  input  logic [2:0]    b_sel,
  input  logic [31:0]   b_wdata,
  input  logic [2:0]    rd_sel,
  output logic [31:0]   rd_data,
  output logic          irq,
  input  logic          bus_idle,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_rdata
);
  logic [1:0]    rst_sync;
  logic          rst_i;
  logic          launch, busy, job_end, rvalid, drained, slot_ok, eng_idle;
  logic [AW-1:0] base;
  logic [WW-1:0] nwords;
  logic [31:0]   crc, rd_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign job_end = busy && drained && eng_idle;
  assign irq     = rd_raw_done;

  logic rd_raw_done;
  memcrc_regs #(.MEM_WORDS(MEM_WORDS), .AW(AW), .WW(WW), .SZW(SZW)) u_regs (
    .clk(clk), .rst_n(rst_i),
    .a_we(a_we), .a_sel(a_sel), .a_wdata(a_wdata),
    .b_we(b_we), .b_sel(b_sel), .b_wdata(b_wdata),
    .rd_sel(rd_sel), .rd_data(rd_raw),
    .job_end(job_end), .crc_in(crc),
    .launch(launch), .base(base), .nwords(nwords), .busy(busy)
  );
  assign rd_data = rd_raw;

  memcrc_regs #(.MEM_WORDS(MEM_WORDS), .AW(AW), .WW(WW), .SZW(SZW)) u_stat (
    .clk(clk), .rst_n(rst_i),
    .a_we(a_we), .a_sel(a_sel), .a_wdata(a_wdata),
    .b_we(b_we), .b_sel(b_sel), .b_wdata(b_wdata),
    .rd_sel(3'd3), .rd_data(stat_word),
    .job_end(job_end), .crc_in(crc),
    .launch(), .base(), .nwords(), .busy()
  );
  logic [31:0] stat_word;
  assign rd_raw_done = stat_word[1];

  memcrc_fetch #(.AW(AW), .WW(WW)) u_fetch (
    .clk(clk), .rst_n(rst_i), .launch(launch), .base(base), .count(nwords),
    .bus_idle(bus_idle), .slot_ok(slot_ok),
    .mem_re(mem_re), .mem_addr(mem_addr), .rvalid(rvalid), .drained(drained)
  );

  memcrc_engine u_eng (
    .clk(clk), .rst_n(rst_i), .init(launch), .load(rvalid), .word(mem_rdata),
    .crc(crc), .slot_ok(slot_ok), .idle(eng_idle)
  );
endmodule

// File: tb/memcrc_scan_test.sv
`timescale 1ns/1ps
module memcrc_scan_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_we, b_we;
  logic [2:0]  a_sel, b_sel, rd_sel;
  logic [31:0] a_wdata, b_wdata, rd_data, mem_rdata;
  logic        irq, bus_idle, mem_re;
  logic [9:0]  mem_addr;

  int errs = 0, checks = 0, cyc = 0;
  int mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int rd_cnt = 0, addr_err = 0, idle_err = 0, gap_err = 0, last_re = 0, exp_base = 0;

  always #2.5 clk = ~clk;

  memcrc_scan uut (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_we), .a_sel(a_sel), .a_wdata(a_wdata),
    .b_we(b_we), .b_sel(b_sel), .b_wdata(b_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq),
    .bus_idle(bus_idle), .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mword(input int a);
    logic [31:0] x;
    x = 32'(a);
    return (x * 32'h0100_0193) ^ 32'hA5C3_0F1E ^ {x[7:0], 24'h0};
  endfunction

  function automatic logic [31:0] ref_crc(input int base, input int n);
    logic [31:0] c;
    logic [31:0] w;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) begin
      w = mword(base + k);
      for (int by = 0; by < 4; by++) begin
        c = c ^ {w[8*by +: 8], 24'h0};
        for (int bt = 0; bt < 8; bt++) c = c[31] ? ((c << 1) ^ 32'h04C1_1DB7) : (c << 1);
      end
    end
    return c;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_re) mem_rdata <= mword(int'(mem_addr));
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      0: bus_idle = 1'b1;
      1: bus_idle = lfsr[0];
      default: bus_idle = (cyc % 3 == 0);
    endcase
  end

  always @(negedge clk) begin
    if (mem_re) begin
      if (!bus_idle) idle_err++;
      if (int'(mem_addr) != exp_base + rd_cnt) addr_err++;
      if (rd_cnt > 0 && cyc - last_re < 4) gap_err++;
      last_re = cyc;
      rd_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit port_b, input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    if (port_b) begin b_we = 1; b_sel = sel; b_wdata = d; end
    else        begin a_we = 1; a_sel = sel; a_wdata = d; end
    @(negedge clk);
    a_we = 0; b_we = 0;
  endtask

  task automatic wr2(input logic [2:0] sel, input logic [31:0] da, input logic [31:0] db);
    @(negedge clk);
    a_we = 1; a_sel = sel; a_wdata = da;
    b_we = 1; b_sel = sel; b_wdata = db;
    @(negedge clk);
    a_we = 0; b_we = 0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    rd_sel = sel;
    #0.5;
    d = rd_data;
  endtask

  task automatic run_job(input int base, input int size, input bit good, input int m, input bit meddle, input bit dual);
    logic [31:0] refv, gold, v;
    int t0, words, waitc;
    words = size * 256;
    refv  = ref_crc(base, words);
    gold  = good ? refv : (refv ^ 32'h1);
    mode  = m;
    wr(0, 3'd0, 32'(base));
    wr(1, 3'd1, 32'(size));
    wr(0, 3'd2, gold);
    rd_cnt = 0; addr_err = 0; idle_err = 0; gap_err = 0; exp_base = base;
    if (dual) wr2(3'd3, 32'h1, 32'h1);
    else      wr(1, 3'd3, 32'h1);
    t0 = cyc;
    if (meddle) begin
      repeat (20) @(negedge clk);
      wr(1, 3'd2, ~gold);
      wr(0, 3'd0, 32'(base + 5));
      wr(1, 3'd3, 32'h1);
    end
    waitc = 0;
    while (irq !== 1'b1 && waitc < 40000) begin @(negedge clk); waitc++; end
    @(negedge clk);
    rd(3'd3, v);
    check(v[3:0] == {1'b0, good, 2'b10}, "R6 status", v, {28'h0, 1'b0, good, 2'b10});
    check(irq == 1'b1, "R6 irq", 32'(irq), 1);
    rd(3'd4, v);
    check(v == refv, "R4 crc", v, refv);
    check(rd_cnt == words, "R3 read count", rd_cnt, words);
    check(addr_err == 0, "R3 address order", addr_err, 0);
    check(idle_err == 0, "R2 idle only", idle_err, 0);
    check(gap_err == 0, "R5 spacing", gap_err, 0);
    check(cyc - t0 >= 4 * words, "R11 min duration", cyc - t0, 4 * words);
    if (meddle) begin
      rd(3'd2, v);
      check(v == gold, "R8 golden kept", v, gold);
      rd(3'd0, v);
      check(v == 32'(base), "R8 start kept", v, base);
    end
    wr(0, 3'd3, 32'h0);
    check(irq == 1'b1, "R7 write 0 keeps done", 32'(irq), 1);
    wr(1, 3'd3, 32'h2);
    rd(3'd3, v);
    check(irq == 1'b0 && v[1] == 1'b0, "R7 clear done", v, 0);
  endtask

  task automatic run_err(input int base, input int size);
    logic [31:0] v;
    wr(0, 3'd0, 32'(base));
    wr(0, 3'd1, 32'(size));
    rd_cnt = 0;
    wr(0, 3'd3, 32'h1);
    @(negedge clk);
    rd(3'd3, v);
    check(v[3:0] == 4'b1010, "R9 error status", v, 32'hA);
    repeat (20) @(negedge clk);
    check(rd_cnt == 0, "R9 no reads", rd_cnt, 0);
    wr(0, 3'd3, 32'h2);
  endtask

  initial begin
    logic [31:0] v;
    a_we = 0; b_we = 0; a_sel = 0; b_sel = 0; a_wdata = 0; b_wdata = 0;
    rd_sel = 0; bus_idle = 1; mem_rdata = 0; rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    rd(3'd3, v);
    check(v == 0, "R1 status", v, 0);
    rd(3'd4, v);
    check(v == 0, "R1 result", v, 0);
    check(irq == 0 && mem_re == 0, "R1 outputs", {irq, mem_re}, 0);

    wr(1, 3'd0, 32'd77);
    rd(3'd0, v);
    check(v == 77, "R12 start index", v, 77);
    rd(3'd7, v);
    check(v == 0, "R12 unmapped", v, 0);
    wr2(3'd1, 32'd1, 32'd2);
    rd(3'd1, v);
    check(v == 1, "R10 A wins", v, 1);

    run_job(0,   1, 1, 0, 0, 0);
    run_job(100, 1, 0, 1, 0, 0);
    run_job(768, 1, 1, 1, 0, 1);   // R10 dual start, ends exactly at memory top
    run_job(3,   2, 1, 0, 1, 0);
    run_job(0,   4, 0, 2, 0, 0);
    run_err(0, 0);
    run_err(769, 1);
    run_err(0, 5);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #950000;
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule